// File: doc/BRIEF.md
# Flash Embedded-Operation Status Responder

This block forms the read path of a parallel NOR-style flash model while an embedded program or erase runs. An external command decoder starts the operation and drives the busy and time-out flags. Array storage outside the block supplies the byte at the current read address. For each read access, the block decides what the 8-bit data bus returns. While an operation is in flight, the bus carries two status bits: a polling bit in position 7 and a toggle bit in position 6. Once the operation has finished, the bus carries the stored byte again.

The interface logic turns every falling edge of chip enable or output enable into a one-cycle read strobe. In the default registered variant, the answer to a strobe appears one clock later, together with a one-cycle valid pulse. The polling bit depends on the operation. For a program it is the inverse of bit 7 of the byte being written. For an erase it is forced low, but only when the read address lies inside the erased sector range. The toggle bit inverts on every status read, whatever the address. The sector-erase time-out window that comes before the erase itself reports status in the same way.

Top module: `flash_status_resp`

## Requirements
- R1: After reset, `rd_data` is 0x00, `rd_valid` is 0, and the toggle state is 0.
- R2: When the parameter REG_OUT is 1, `rd_valid` is high in exactly the cycle after each `rd_stb` pulse, and `rd_data` holds its value in every cycle that follows a cycle without a strobe.
- R3: When neither `op_busy` nor `erase_wait` is set, a read returns `arr_byte` unchanged on all eight bits.
- R4: While a program is active (`op_kind` = 0 and `op_busy` set), bit 7 of the read result is the inverse of `prog_byte[7]`.
- R5: While an erase is active (`op_kind` = 1), a read whose sector index lies between `ers_lo` and `ers_hi` inclusive returns 0 in bit 7. The sector index is `rd_addr[ADDR_W-1 -: SECT_W]`.
- R6: While an erase is active, a read whose sector index lies outside the erased range returns `arr_byte[7]` in bit 7.
- R7: Each read that happens during status reporting returns the toggle state in bit 6 and then inverts that state, at any address. An `op_start` pulse clears the toggle state to 0, so the first status read of a new operation returns 0 in bit 6.
- R8: While `erase_wait` is set, reads report erase status (R5, R6, R7) even if `op_busy` is low.
- R9: During status reporting, bits 5 to 0 of the read result are 0.
- R10: Once status reporting ends, the toggle state stops changing, and reads return the full array byte. If busy is raised again without `op_start`, the toggle continues from the value where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_stb | input | 1 | One-cycle read access strobe |
| op_start | input | 1 | Pulse marking the start of a new embedded operation |
| op_busy | input | 1 | Embedded operation in progress |
| erase_wait | input | 1 | Sector-erase time-out window is open |
| op_kind | input | 1 | Operation type: 0 = program, 1 = erase |
| prog_byte | input | 8 | Byte last given to the program operation |
| rd_addr | input | ADDR_W | Read address |
| ers_lo | input | SECT_W | Lowest sector index being erased |
| ers_hi | input | SECT_W | Highest sector index being erased |
| arr_byte | input | 8 | Array content at `rd_addr` |
| rd_data | output | 8 | Read result |
| rd_valid | output | 1 | Read result valid pulse |

## Verification
The assertions rely on several conditions on the inputs:
- `op_kind` and the sector range stay constant for the whole of an operation.
- `erase_wait` is set only for an erase.
- `op_start` never coincides with `rd_stb`.
- `ers_lo` does not exceed `ers_hi`.

The bench meets these conditions as follows. It changes the operation fields only inside its operation-start task, which pulses `op_start` with no strobe. It draws each range with its upper bound at or above its lower bound. It randomizes only the address, the array byte and the programmed byte between reads.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
   localparam int DQ_W = 8;
   localparam int POLL_BIT = 7;
   localparam int TOG_BIT  = 6;

   typedef enum logic {
      OP_PROGRAM = 1'b0,
      OP_ERASE   = 1'b1
   } fsr_op_e;
endpackage

// File: rtl/fsr_sector_hit.sv
module fsr_sector_hit #(
   parameter int ADDR_W = 16,
   parameter int SECT_W = 3
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [SECT_W-1:0] lo,
   input  logic [SECT_W-1:0] hi,
   output logic              hit
);
   localparam int SECT_LSB = ADDR_W - SECT_W;

   logic [SECT_W-1:0] sect;

   assign sect = addr[SECT_LSB +: SECT_W];
   assign hit  = (sect >= lo) && (sect <= hi);
endmodule

// File: rtl/fsr_toggle.sv
module fsr_toggle (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic adv,
   output logic q
);
   always_ff @(posedge clk) begin
      if (!rst_n)   q <= 1'b0;
      else if (clr) q <= 1'b0;
      else if (adv) q <= ~q;
   end

   // R7: a start pulse leaves the toggle at zero
   a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (q == 1'b0));
   // R7: every advancing access flips the state
   a_r7_flip: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !clr) |=> (q != $past(q)));
   // R10: without access or start the state holds
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv && !clr) |=> $stable(q));
endmodule

// File: rtl/fsr_compose.sv
module fsr_compose
   import fsr_pkg::*;
(
   input  logic            active,
   input  fsr_op_e         kind,
   input  logic            hit,
   input  logic            prog_b7,
   input  logic [DQ_W-1:0] arr,
   input  logic            tog,
   output logic [DQ_W-1:0] word
);
   logic poll;

   always_comb begin
      if (kind == OP_PROGRAM) poll = ~prog_b7;
      else if (hit)           poll = 1'b0;
      else                    poll = arr[POLL_BIT];
   end

   always_comb begin
      if (active) begin
         word           = '0;
         word[POLL_BIT] = poll;
         word[TOG_BIT]  = tog;
      end else begin
         word = arr;
      end
   end

   always_comb begin
      if (active) a_r9_low_zero: assert (word[TOG_BIT-1:0] == '0);
   end
endmodule

// File: rtl/flash_status_resp.sv
module flash_status_resp
   import fsr_pkg::*;
#(
   parameter int ADDR_W  = 16,
   parameter int SECT_W  = 3,
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_stb,
   input  logic              op_start,
   input  logic              op_busy,
   input  logic              erase_wait,
   input  logic              op_kind,
   input  logic [7:0]        prog_byte,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [SECT_W-1:0] ers_lo,
   input  logic [SECT_W-1:0] ers_hi,
   input  logic [7:0]        arr_byte,
   output logic [7:0]        rd_data,
   output logic              rd_valid
);
   if (SECT_W < 1 || SECT_W > ADDR_W) begin : g_bad_sect
      $error("SECT_W must lie in 1..ADDR_W");
   end
   if (DQ_W != 8) begin : g_bad_dq
      $error("data bus must be eight bits");
   end

   fsr_op_e     kind;
   logic        active;
   logic        hit;
   logic        tog;
   logic [7:0]  word;

   assign kind   = fsr_op_e'(op_kind);
   assign active = op_busy | erase_wait;

   fsr_sector_hit #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) i_hit (
      .addr(rd_addr), .lo(ers_lo), .hi(ers_hi), .hit(hit)
   );

   fsr_toggle i_tog (
      .clk(clk), .rst_n(rst_n), .clr(op_start),
      .adv(rd_stb & active), .q(tog)
   );

   fsr_compose i_comp (
      .active(active), .kind(kind), .hit(hit), .prog_b7(prog_byte[7]),
      .arr(arr_byte), .tog(tog), .word(word)
   );

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
         end else begin
            rd_valid <= rd_stb;
            if (rd_stb) rd_data <= word;
         end
      end

      // R2: valid pulse follows each strobe by one cycle
      a_r2_valid: assert property (@(posedge clk) disable iff (!rst_n)
         rd_stb |=> rd_valid);
      a_r2_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
         !rd_stb |=> !rd_valid);
      // R2: data holds between reads
      a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
         !rd_stb |=> $stable(rd_data));
      // R3: idle read passes the array byte
      a_r3_idle: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_stb && !active) |=> (rd_data == $past(arr_byte)));
      // R4: program polling bit is inverted
      a_r4_prog_poll: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_stb && active && kind == OP_PROGRAM) |=>
            (rd_data[7] == ~$past(prog_byte[7])));
      // R5: erase polling bit is low inside the range
      a_r5_erase_poll: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_stb && active && kind == OP_ERASE && hit) |=> (rd_data[7] == 1'b0));
      // R7: status read shows the toggle state before it flips
      a_r7_dq6: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_stb && active) |=> (rd_data[6] == $past(tog)));
      // R9: low bits are zero on status reads
      a_r9_low: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_stb && active) |=> (rd_data[5:0] == 6'd0));
   end else begin : g_comb
      assign rd_valid = rd_stb;
      assign rd_data  = rd_stb ? word : 8'h00;
   end
endmodule

// File: tb/test_flash_status_resp.sv
module test_flash_status_resp;
   localparam int ADDR_W = 16;
   localparam int SECT_W = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rd_stb = 1'b0, op_start = 1'b0, op_busy = 1'b0, erase_wait = 1'b0;
   logic op_kind = 1'b0;
   logic [7:0] prog_byte = 8'h00, arr_byte = 8'h00;
   logic [ADDR_W-1:0] rd_addr = '0;
   logic [SECT_W-1:0] ers_lo = '0, ers_hi = '0;
   logic [7:0] rd_data;
   logic rd_valid;

   int checks = 0;
   int errors = 0;
   bit exp_tog = 1'b0;
   bit post_op = 1'b0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   flash_status_resp #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) i_flash_status_resp (
      .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .op_start(op_start),
      .op_busy(op_busy), .erase_wait(erase_wait), .op_kind(op_kind),
      .prog_byte(prog_byte), .rd_addr(rd_addr), .ers_lo(ers_lo),
      .ers_hi(ers_hi), .arr_byte(arr_byte), .rd_data(rd_data),
      .rd_valid(rd_valid)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic bit in_range(input logic [ADDR_W-1:0] a);
      logic [SECT_W-1:0] s;
      s = a[ADDR_W-1 -: SECT_W];
      return (s >= ers_lo) && (s <= ers_hi);
   endfunction

   function automatic logic [7:0] f_exp(input logic [ADDR_W-1:0] a, input logic [7:0] arr);
      if (!(op_busy || erase_wait)) return arr;
      if (op_kind == 1'b0) return {~prog_byte[7], exp_tog, 6'b0};
      if (in_range(a)) return {1'b0, exp_tog, 6'b0};
      return {arr[7], exp_tog, 6'b0};
   endfunction

   task automatic rd(input logic [ADDR_W-1:0] a, input logic [7:0] arr);
      logic [7:0] e;
      logic [7:0] held;
      string tag7;
      bit act;
      act = op_busy || erase_wait;
      @(negedge clk);
      rd_addr = a; arr_byte = arr; rd_stb = 1'b1;
      e = f_exp(a, arr);
      if (!act) tag7 = post_op ? "R10" : "R3";
      else if (erase_wait) tag7 = "R8";
      else if (op_kind == 1'b0) tag7 = "R4";
      else tag7 = in_range(a) ? "R5" : "R6";
      @(negedge clk);
      rd_stb = 1'b0;
      check("R2 valid", {31'd0, rd_valid}, 32'd1);
      if (act) begin
         check({tag7, " dq7"}, {31'd0, rd_data[7]}, {31'd0, e[7]});
         check("R7 dq6", {31'd0, rd_data[6]}, {31'd0, e[6]});
         check("R9 low bits", {26'd0, rd_data[5:0]}, 32'd0);
         exp_tog = ~exp_tog;
      end else begin
         check({tag7, " byte"}, {24'd0, rd_data}, {24'd0, e});
      end
      held = rd_data;
      arr_byte = ~arr;
      @(negedge clk);
      check("R2 no valid", {31'd0, rd_valid}, 32'd0);
      check("R2 hold", {24'd0, rd_data}, {24'd0, held});
   endtask

   task automatic start_op(input logic kind);
      @(negedge clk);
      op_kind = kind; op_start = 1'b1;
      prog_byte = 8'($urandom);
      @(negedge clk);
      op_start = 1'b0;
      exp_tog = 1'b0;
      post_op = 1'b0;
   endtask

   task automatic report;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=hung expected=done");
         report();
      end
   end

   initial begin
      logic [ADDR_W-1:0] a;
      void'($urandom(32'h5EED_0042));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 data", {24'd0, rd_data}, 32'd0);
      check("R1 valid", {31'd0, rd_valid}, 32'd0);

      // R3 idle reads
      for (int i = 0; i < 8; i++) rd(ADDR_W'($urandom), 8'($urandom));

      // R4/R7 program, both polarities of bit 7
      for (int k = 0; k < 4; k++) begin
         start_op(1'b0);
         prog_byte[7] = k[0];
         op_busy = 1'b1;
         for (int i = 0; i < 5; i++) rd(ADDR_W'($urandom), 8'($urandom));
         op_busy = 1'b0;
         post_op = 1'b1;
         // R10 completion returns the full array byte
         rd(ADDR_W'($urandom), {prog_byte[7], 7'($urandom)});
         rd(ADDR_W'($urandom), 8'($urandom));
         // R10 busy again without a start: toggle continues
         op_busy = 1'b1;
         rd(ADDR_W'($urandom), 8'($urandom));
         op_busy = 1'b0;
      end

      // R5/R6/R8 erase with time-out window then busy
      for (int k = 0; k < 6; k++) begin
         logic [SECT_W-1:0] lo;
         lo = SECT_W'($urandom);
         ers_lo = lo;
         ers_hi = lo + SECT_W'($urandom % (32'(1 << SECT_W) - 32'(lo)));
         start_op(1'b1);
         erase_wait = 1'b1;
         for (int i = 0; i < 3; i++) rd(ADDR_W'($urandom), 8'($urandom));
         erase_wait = 1'b0;
         op_busy = 1'b1;
         // corners: range bounds and neighbours
         a = '0; a[ADDR_W-1 -: SECT_W] = ers_lo; rd(a, 8'hFF);
         a = '1; a[ADDR_W-1 -: SECT_W] = ers_hi; rd(a, 8'hFF);
         if (ers_hi != '1) begin
            a = '0; a[ADDR_W-1 -: SECT_W] = ers_hi + 1'b1; rd(a, 8'h80);
         end
         if (ers_lo != '0) begin
            a = '1; a[ADDR_W-1 -: SECT_W] = ers_lo - 1'b1; rd(a, 8'h35);
         end
         for (int i = 0; i < 6; i++) rd(ADDR_W'($urandom), 8'($urandom));
         op_busy = 1'b0;
         post_op = 1'b1;
         rd(ADDR_W'($urandom), 8'hFF);
      end

      // R7 fresh start clears toggle
      start_op(1'b0);
      op_busy = 1'b1;
      rd(ADDR_W'($urandom), 8'($urandom));
      op_busy = 1'b0;

      done = 1'b1;
      report();
   end
endmodule